// File: doc/BRIEF.md
# Per-line input deglitch bank with status and change detect

This block takes a bank of asynchronous general-purpose input lines and produces, for each line, three views of its level. The peripheral view is the synchronized line, never filtered. The status view is the line level that software reads through a small APB register port. The change view is a one-cycle flag that an interrupt controller can collect. Each line has its own glitch filter, which software turns on and off. Only the status and change views pass through the filter.

The filter samples each line on both clock edges, which gives it half-cycle resolution. At each rising edge it takes a new value only when two consecutive half-cycle samples agree. A spike shorter than half a period is therefore never seen, and a pulse longer than one period always gets through. The enables are changed through a pair of write-one registers, one that sets bits and one that clears them, and are read back through a read-only status register. All enables clear at reset. The input `run_i` models a gated controller clock: while it is low, the status view keeps the levels captured when it fell, while the peripheral view keeps following the pins.

Register port: `paddr_i` selects a word. Offset 0x0 is the enable-set register and offset 0x4 is the enable-clear register; both are write-only. Offset 0x8 reads the enable status in bits [N_LINES-1:0]. Offset 0xC reads the line levels in bits [N_LINES-1:0]. N_LINES may be 1 to 32. SYNC_EXTRA is the number of added settling stages on both sample paths and defaults to 1.

Top module: `gpio_deglitch_bank`

## Requirements
- R1: Writing the enable-set register (offset 0x0) ORs the low N_LINES bits of write data into the enable status; zero bits leave their enables unchanged.
- R2: Writing the enable-clear register (offset 0x4) clears each enable whose write-data bit is 1; zero bits leave their enables unchanged.
- R3: The enable status (offset 0x8) is read-only: writing it changes nothing. All enables are 0 after reset.
- R4: Bit i of the level register (offset 0xC) is the filtered level of line i when its enable is 1, and the raw synchronized level otherwise, whatever drives the line.
- R5: With the filter enabled, a pulse shorter than half a clock period never changes the level register and never raises the change flag.
- R6: With the filter enabled, a pulse longer than one clock period always appears in the level register and raises the change flag on both of its edges.
- R7: Say a pin value is first sampled at rising edge k. With the filter off, that value is in the level register after edge k+SYNC_EXTRA+1. With the filter on, a change just before a rising edge appears one cycle later than it does unfiltered, and a change just before a falling edge appears with no extra delay.
- R8: `periph_o[i]` carries the pin value sampled at rising edge k from edge k+SYNC_EXTRA onward. It is never filtered, even when the line's filter is enabled.
- R9: `chg_o[i]` is 1 for exactly the cycle after a rising edge at which level bit i differs from its value at the previous rising edge.
- R10: While `run_i` is 0, the level register holds the values it had when `run_i` fell and no change flag rises; `periph_o` keeps following the pins. After `run_i` returns to 1, the levels update again.
- R11: Every access takes two cycles: a setup cycle, then an access cycle with `penable_i` high. `pready_o` is always 1. A write takes effect at the end of its access cycle. `prdata_o` is valid during a read's access cycle. Reads of offsets other than 0x8 and 0xC return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; both edges sample the pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | High while the controller clock runs; low freezes the level view |
| psel_i | input | 1 | APB select |
| penable_i | input | 1 | APB enable (access phase) |
| pwrite_i | input | 1 | APB write when 1, read when 0 |
| paddr_i | input | 4 | APB byte address of the word |
| pwdata_i | input | 32 | APB write data |
| prdata_o | output | 32 | APB read data |
| pready_o | output | 1 | APB ready, always 1 |
| pin_i | input | N_LINES | Asynchronous input lines |
| periph_o | output | N_LINES | Synchronized, unfiltered lines for peripherals |
| chg_o | output | N_LINES | One-cycle change flags for the interrupt logic |

## Verification
The assertions take for granted that the register port follows the two-phase protocol: `penable_i` is high only while `psel_i` is high, and only in the cycle after a setup cycle. They assume nothing about the pins, which may change at any instant, including close to either clock edge. The bench's write and read tasks always drive a setup cycle, then one access cycle, then an idle cycle. The pin stimulus is placed deliberately a few nanoseconds before or after chosen edges, to pin down which half-cycle sample each change lands in.

// File: rtl/gdf_pkg.sv
package gdf_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;

  // Word offsets of the register port
  localparam logic [ADDR_W-1:0] OFF_SET  = 4'h0;  // write 1 to enable filter
  localparam logic [ADDR_W-1:0] OFF_CLR  = 4'h4;  // write 1 to disable filter
  localparam logic [ADDR_W-1:0] OFF_STAT = 4'h8;  // filter enables, read-only
  localparam logic [ADDR_W-1:0] OFF_LVL  = 4'hC;  // line levels, read-only
endpackage

// File: rtl/gdf_regs.sv
module gdf_regs
  import gdf_pkg::*;
#(
  parameter int N_LINES = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               psel_i,
  input  logic               penable_i,
  input  logic               pwrite_i,
  input  logic [ADDR_W-1:0]  paddr_i,
  input  logic [DATA_W-1:0]  pwdata_i,
  input  logic [N_LINES-1:0] level_i,
  output logic [N_LINES-1:0] en_o,
  output logic [DATA_W-1:0]  prdata_o
);
  logic               wr_acc;
  logic               do_set;
  logic               do_clr;
  logic [N_LINES-1:0] en_q;
  logic [N_LINES-1:0] wmask;

  assign wr_acc = psel_i & penable_i & pwrite_i;
  assign do_set = wr_acc && (paddr_i == OFF_SET);
  assign do_clr = wr_acc && (paddr_i == OFF_CLR);
  assign wmask  = pwdata_i[N_LINES-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en_q <= '0;
    else if (do_set) en_q <= en_q | wmask;
    else if (do_clr) en_q <= en_q & ~wmask;
  end

  assign en_o = en_q;

  always_comb begin
    prdata_o = '0;
    if (psel_i && !pwrite_i) begin
      case (paddr_i)
        OFF_STAT: prdata_o[N_LINES-1:0] = en_q;
        OFF_LVL:  prdata_o[N_LINES-1:0] = level_i;
        default:  prdata_o = '0;
      endcase
    end
  end

  a_r1_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
    do_set |=> (en_q == ($past(en_q) | $past(wmask))));

  a_r2_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
    do_clr |=> (en_q == ($past(en_q) & ~$past(wmask))));

  a_r3_hold_enables: assert property (@(posedge clk) disable iff (!rst_n)
    !(do_set || do_clr) |=> $stable(en_q));

  a_r11_enable_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
    penable_i |-> psel_i);

  a_r11_setup_before_access: assert property (@(posedge clk) disable iff (!rst_n)
    (psel_i && penable_i) |-> $past(psel_i && !penable_i));
endmodule

// File: rtl/gdf_line.sv
module gdf_line #(
  parameter int SYNC_EXTRA = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic pin_i,
  input  logic en_i,
  output logic periph_o,
  output logic lvl_o
);
  logic n_smp;   // sample taken at falling edge
  logic p0;      // sample taken at rising edge k
  logic nq;      // falling-edge sample moved onto the rising-edge domain
  logic p0_s;
  logic nq_s;
  logic p1_s;    // previous rising-edge sample after settling
  logic raw_q;
  logic filt_q;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) n_smp <= 1'b0;
    else        n_smp <= pin_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p0 <= 1'b0;
      nq <= 1'b0;
    end else begin
      p0 <= pin_i;
      nq <= n_smp;
    end
  end

  generate
    if (SYNC_EXTRA == 0) begin : g_nosync
      assign p0_s = p0;
      assign nq_s = nq;
    end else begin : g_sync
      logic [SYNC_EXTRA-1:0] pd;
      logic [SYNC_EXTRA-1:0] nd;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pd <= '0;
          nd <= '0;
        end else begin
          pd[0] <= p0;
          nd[0] <= nq;
          for (int i = 1; i < SYNC_EXTRA; i++) begin
            pd[i] <= pd[i-1];
            nd[i] <= nd[i-1];
          end
        end
      end
      assign p0_s = pd[SYNC_EXTRA-1];
      assign nq_s = nd[SYNC_EXTRA-1];
    end
  endgenerate

  // Filter: the newer pair (fall, rise) wins; otherwise the older pair
  // (rise, fall) may still qualify, so a pulse over one period passes.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p1_s   <= 1'b0;
      raw_q  <= 1'b0;
      filt_q <= 1'b0;
    end else begin
      p1_s <= p0_s;
      if (run_i) begin
        raw_q <= p0_s;
        if (nq_s == p0_s)      filt_q <= p0_s;
        else if (p1_s == nq_s) filt_q <= nq_s;
      end
    end
  end

  assign periph_o = p0_s;
  assign lvl_o    = en_i ? filt_q : raw_q;

  // R5/R6: filtered value moves only on two agreeing half-cycle samples
  a_r5_filter_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_q != $past(filt_q)) |->
      (($past(p0_s) == $past(nq_s)) || ($past(p1_s) == $past(nq_s))));

  a_r10_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> ($stable(raw_q) && $stable(filt_q)));
endmodule

// File: rtl/gdf_change.sv
module gdf_change #(
  parameter int N_LINES = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] level_i,
  output logic [N_LINES-1:0] chg_o
);
  logic [N_LINES-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= level_i;
  end

  assign chg_o = level_i ^ prev_q;

  a_r9_flag_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(chg_o) != '0 && $stable(level_i)) |-> (chg_o == '0));
endmodule

// File: rtl/gpio_deglitch_bank.sv
module gpio_deglitch_bank
  import gdf_pkg::*;
#(
  parameter int N_LINES    = 8,
  parameter int SYNC_EXTRA = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run_i,
  input  logic               psel_i,
  input  logic               penable_i,
  input  logic               pwrite_i,
  input  logic [ADDR_W-1:0]  paddr_i,
  input  logic [DATA_W-1:0]  pwdata_i,
  output logic [DATA_W-1:0]  prdata_o,
  output logic               pready_o,
  input  logic [N_LINES-1:0] pin_i,
  output logic [N_LINES-1:0] periph_o,
  output logic [N_LINES-1:0] chg_o
);
  logic [N_LINES-1:0] en;
  logic [N_LINES-1:0] level;

  assign pready_o = 1'b1;

  gdf_regs #(.N_LINES(N_LINES)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .psel_i   (psel_i),
    .penable_i(penable_i),
    .pwrite_i (pwrite_i),
    .paddr_i  (paddr_i),
    .pwdata_i (pwdata_i),
    .level_i  (level),
    .en_o     (en),
    .prdata_o (prdata_o)
  );

  generate
    for (genvar g = 0; g < N_LINES; g++) begin : g_line
      gdf_line #(.SYNC_EXTRA(SYNC_EXTRA)) u_line (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (run_i),
        .pin_i   (pin_i[g]),
        .en_i    (en[g]),
        .periph_o(periph_o[g]),
        .lvl_o   (level[g])
      );
    end
  endgenerate

  gdf_change #(.N_LINES(N_LINES)) u_chg (
    .clk    (clk),
    .rst_n  (rst_n),
    .level_i(level),
    .chg_o  (chg_o)
  );

  // R10: with the clock model stopped, no level change may be flagged
  a_r10_no_flag_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && $past(!run_i) && $stable(en)) |-> (chg_o == '0));
endmodule

// File: tb/test_gpio_deglitch_bank.sv
`timescale 1ns/1ps
module test_gpio_deglitch_bank;
  import gdf_pkg::*;
  localparam int N = 8;
  localparam int S = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b1;
  logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [ADDR_W-1:0] paddr = '0;
  logic [DATA_W-1:0] pwdata = '0;
  logic [DATA_W-1:0] prdata;
  logic pready;
  logic [N-1:0] pins = '0;
  logic [N-1:0] periph, chg;
  int nchk = 0, nfail = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  gpio_deglitch_bank #(.N_LINES(N), .SYNC_EXTRA(S)) i_gpio_deglitch_bank (
    .clk(clk), .rst_n(rst_n), .run_i(run),
    .psel_i(psel), .penable_i(penable), .pwrite_i(pwrite),
    .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prdata), .pready_o(pready),
    .pin_i(pins), .periph_o(periph), .chg_o(chg)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic apb_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(posedge clk); #1;
    penable = 1;
    @(posedge clk); #1;
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_read(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(posedge clk); #1;
    penable = 1;
    #1 d = prdata;
    @(posedge clk); #1;
    psel = 0; penable = 0;
  endtask

  task automatic settle();
    repeat (S + 6) @(posedge clk);
    #1;
  endtask

  task automatic count_win(input int ncyc, output int c0, output int c1, output int pk);
    c0 = 0; c1 = 0; pk = 0;
    for (int c = 0; c < ncyc; c++) begin
      @(posedge clk); #1;
      if (chg[0]) c0++;
      if (chg[1]) c1++;
      if (periph[0]) pk++;
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R3 reset chg", 32'(chg), 0);
    check("R8 reset periph", 32'(periph), 0);
    check("R11 pready", 32'(pready), 1);
    apb_read(OFF_STAT, d); check("R3 reset enables", d, 0);
    apb_read(OFF_LVL, d);  check("R4 reset levels", d, 0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    apb_write(OFF_SET, 32'h05); apb_read(OFF_STAT, d); check("R1 set 05", d, 32'h05);
    apb_write(OFF_SET, 32'h02); apb_read(OFF_STAT, d); check("R1 zeros keep", d, 32'h07);
    apb_write(OFF_CLR, 32'h04); apb_read(OFF_STAT, d); check("R2 clear 04", d, 32'h03);
    apb_write(OFF_CLR, 32'h00); apb_read(OFF_STAT, d); check("R2 zeros keep", d, 32'h03);
    apb_write(OFF_STAT, 32'hFF); apb_read(OFF_STAT, d); check("R3 read-only", d, 32'h03);
    apb_read(OFF_SET, d); check("R11 unmapped read", d, 0);
    apb_write(OFF_CLR, 32'hFF);
    apb_write(OFF_SET, 32'h01);  // line 0 filtered, line 1 raw
    apb_read(OFF_STAT, d); check("R1 final", d, 32'h01);
  endtask

  task automatic measure(input int c0, output int f0, output int f1, output int fp);
    f0 = -1; f1 = -1; fp = -1;
    for (int c = c0; c < c0 + 7; c++) begin
      @(posedge clk); #1;
      if (chg[0] && f0 < 0) f0 = c;
      if (chg[1] && f1 < 0) f1 = c;
      if (periph[1] && fp < 0) fp = c;
    end
  endtask

  task automatic t_latency();
    int f0, f1, fp;
    // change 1 ns before a rising edge
    @(posedge clk); #7 pins[1:0] = 2'b11;
    measure(0, f0, f1, fp);
    check("R7 raw before rise", 32'(f1), 32'(S + 1));
    check("R7 filt before rise", 32'(f0), 32'(S + 2));
    check("R8 periph before rise", 32'(fp), 32'(S));
    pins[1:0] = 2'b00; settle();
    // change 1 ns before a falling edge
    @(posedge clk); #3 pins[1:0] = 2'b11;
    measure(1, f0, f1, fp);
    check("R7 raw before fall", 32'(f1), 32'(S + 2));
    check("R7 filt before fall", 32'(f0), 32'(S + 2));
    check("R8 periph before fall", 32'(fp), 32'(S + 1));
    pins[1:0] = 2'b00; settle();
  endtask

  task automatic t_glitch();
    int c0, c1, pk;
    // 2 ns spike across a rising edge
    @(posedge clk); #7 pins[1:0] = 2'b11; #2 pins[1:0] = 2'b00;
    count_win(8, c0, c1, pk);
    check("R5 filtered ignores spike", 32'(c0), 0);
    check("R9 raw spike two flags", 32'(c1), 2);
    check("R8 periph sees spike", 32'(pk), 1);
    // 2 ns spike across a falling edge
    @(posedge clk); #3 pins[1:0] = 2'b11; #2 pins[1:0] = 2'b00;
    count_win(8, c0, c1, pk);
    check("R5 filtered ignores fall spike", 32'(c0), 0);
    settle();
  endtask

  task automatic t_long();
    int c0, c1, pk;
    @(posedge clk); #5 pins[1:0] = 2'b11; #9 pins[1:0] = 2'b00;
    count_win(10, c0, c1, pk);
    check("R6 pulse after fall passes", 32'(c0), 2);
    @(posedge clk); #1 pins[1:0] = 2'b11; #9 pins[1:0] = 2'b00;
    count_win(10, c0, c1, pk);
    check("R6 pulse after rise passes", 32'(c0), 2);
    settle();
  endtask

  task automatic t_freeze();
    int c0, c1, pk;
    logic [31:0] d;
    @(posedge clk); #1 run = 0;
    pins[1:0] = 2'b11;
    count_win(6, c0, c1, pk);
    check("R10 no flag frozen", 32'(c0 + c1), 0);
    check("R10 periph live", 32'(periph[1:0]), 32'h3);
    apb_read(OFF_LVL, d); check("R10 level held", d, 0);
    @(posedge clk); #1 run = 1;
    settle();
    apb_read(OFF_LVL, d); check("R10 level resumes", d, 32'h03);
    pins[1:0] = 2'b00; settle();
  endtask

  task automatic t_mux();
    logic [31:0] d;
    pins = 8'h83; settle();
    apb_read(OFF_LVL, d); check("R4 mixed lines", d, 32'h83);
    apb_write(OFF_CLR, 32'h01);
    apb_read(OFF_STAT, d); check("R2 all off", d, 0);
    apb_read(OFF_LVL, d); check("R4 raw after disable", d, 32'h83);
    pins = '0; settle();
    apb_read(OFF_LVL, d); check("R4 back to zero", d, 0);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;
    t_reset();
    t_regs();
    t_latency();
    t_glitch();
    t_long();
    t_freeze();
    t_mux();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule